// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration space reached through two adjacent I/O addresses. The lower address is the index port and the upper one is the data port. After reset the space is locked. It opens only after the entry key byte 0x87 has been written to the index port twice in a row. Once it is open, writing a byte to the index port selects a configuration register, and reads or writes on the data port reach that register. Writing the exit byte 0xAA to the index port locks the space again.

The global registers are few:
- Index 0x07 holds the logical-device number. It can be read and written.
- Indices 0x20 and 0x21 return the two bytes of the device ID, high byte first.
- Index 0x22 returns the revision byte.
- Indices 0x23 and 0x24 return the manufacturer ID 0x1934, high byte first.
- When the logical-device number equals the window device (0x06 by default), indices at or above 0x30 are passed to a banked register file outside this block. The pass-through uses a select strobe, a write strobe, the index and the write byte. The read byte comes back combinationally from that register file.

A strap parameter places the port pair at 0x2E/0x2F or at 0x4E/0x4F. Host accesses arrive as single-cycle read or write strobes with an address. The read byte is produced combinationally in the same cycle.

Top module: `cfg_port`

## Requirements
- R1: Reset leaves the port locked. Once the port has been unlocked, the index reads 0x00 and the logical-device register (index 0x07) reads 0x00.
- R2: While locked, every read of the index port or the data port returns 0xFF. Data-port writes do not change any register.
- R3: The port unlocks only after two consecutive index-port writes of 0x87. Any other index-port byte after a single 0x87 returns the sequence to its start.
- R4: An index-port write of 0xAA while unlocked relocks the port. The index and the logical-device register keep their values, and the next unlock shows them unchanged.
- R5: While unlocked, an index-port write of any byte other than 0xAA latches that byte as the index, and a read of the index port returns it.
- R6: While unlocked with index 0x07, a data-port write stores the byte as the logical-device number and a data-port read returns it.
- R7: The identification bytes are read-only, and data-port writes to them are discarded:
  - 0x20 returns DEV_ID[15:8] and 0x21 returns DEV_ID[7:0].
  - 0x22 returns DEV_REV.
  - 0x23 returns 0x19 and 0x24 returns 0x34.
- R8: A data-port access while unlocked, with the logical device equal to WIN_LD and the index at or above WIN_BASE, raises win_sel_o with win_addr_o equal to the index. A write also raises win_we_o with win_wdata_o equal to the written byte, and a read returns win_rdata_i. Otherwise win_sel_o and win_we_o stay low.
- R9: Only the strapped index address (0x2E when BASE_SEL=0, 0x4E when BASE_SEL=1) and the address one above it respond. Accesses to any other address read 0xFF and change nothing.
- R10: A data-port read while unlocked at an index that is neither a global register nor an open window location returns 0x00. This also covers window indices while another logical device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe, one cycle |
| io_rd_i | input | 1 | Host read strobe, one cycle |
| io_wdata_i | input | 8 | Host write byte |
| io_rdata_o | output | 8 | Host read byte (0xFF when not driven) |
| win_sel_o | output | 1 | Window access strobe |
| win_we_o | output | 1 | Window write strobe |
| win_addr_o | output | 8 | Window register index |
| win_wdata_o | output | 8 | Window write byte |
| win_rdata_i | input | 8 | Window read byte |

## Verification
The bench breaks the key sequence with a foreign byte between two 0x87 writes. A design that counted non-consecutive keys would open there and return real register data instead of 0xFF. It also writes the identification bytes and writes while locked. A design that let those writes through would show altered IDs or a changed logical-device number after the next unlock. The window boundaries are probed at index 0x2F, at 0x30 and with a different logical device selected. An off-by-one compare or a missing device check shows up as a stray window strobe or a wrong read byte. Finally, the exit key sent to the unstrapped base address must leave the port open, and three 0x87 writes in a row must latch 0x87 as the index.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {LK_SHUT = 2'd0, LK_HALF = 2'd1, LK_OPEN = 2'd2} lock_e;
  localparam logic [7:0]  KEY_ENTER = 8'h87;
  localparam logic [7:0]  KEY_EXIT  = 8'hAA;
  localparam logic [7:0]  REG_LDSEL = 8'h07;
  localparam logic [7:0]  REG_ID_HI = 8'h20;
  localparam logic [7:0]  REG_ID_LO = 8'h21;
  localparam logic [7:0]  REG_REV   = 8'h22;
  localparam logic [7:0]  REG_MF_HI = 8'h23;
  localparam logic [7:0]  REG_MF_LO = 8'h24;
  localparam logic [15:0] MFG_ID    = 16'h1934;
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  output logic       open_o,
  output logic       idx_load_o
);
  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      unique case (state_q)
        LK_SHUT: state_d = (key_i == KEY_ENTER) ? LK_HALF : LK_SHUT;
        LK_HALF: state_d = (key_i == KEY_ENTER) ? LK_OPEN : LK_SHUT;
        LK_OPEN: state_d = (key_i == KEY_EXIT)  ? LK_SHUT : LK_OPEN;
        default: state_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= LK_SHUT;
    else         state_q <= state_d;

  assign open_o     = (state_q == LK_OPEN);
  assign idx_load_o = key_wr_i && open_o && (key_i != KEY_EXIT);

  assert_unlock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr_i && key_i == KEY_ENTER && state_q == LK_HALF));
  assert_relock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && key_wr_i && key_i == KEY_EXIT) |=> !open_o);
  assert_break_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_HALF && key_wr_i && key_i != KEY_ENTER) |=> state_q == LK_SHUT);
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID   = 16'h1010,
  parameter logic [7:0]  DEV_REV  = 8'h01,
  parameter logic [7:0]  WIN_LD   = 8'h06,
  parameter logic [7:0]  WIN_BASE = 8'h30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       open_i,
  input  logic       idx_load_i,
  input  logic [7:0] wdata_i,
  input  logic       dat_acc_i,
  input  logic       dat_wr_i,
  input  logic [7:0] win_rdata_i,
  output logic [7:0] idx_o,
  output logic [7:0] dat_rdata_o,
  output logic       win_sel_o,
  output logic       win_we_o
);
  logic [7:0] idx_q, ld_sel_q;
  logic       win_hit;

  assign win_hit = (ld_sel_q == WIN_LD) && (idx_q >= WIN_BASE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         idx_q <= '0;
    else if (idx_load_i) idx_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                ld_sel_q <= '0;
    else if (dat_wr_i && idx_q == REG_LDSEL)    ld_sel_q <= wdata_i;

  always_comb begin
    unique case (idx_q)
      REG_LDSEL: dat_rdata_o = ld_sel_q;
      REG_ID_HI: dat_rdata_o = DEV_ID[15:8];
      REG_ID_LO: dat_rdata_o = DEV_ID[7:0];
      REG_REV:   dat_rdata_o = DEV_REV;
      REG_MF_HI: dat_rdata_o = MFG_ID[15:8];
      REG_MF_LO: dat_rdata_o = MFG_ID[7:0];
      default:   dat_rdata_o = win_hit ? win_rdata_i : 8'h00;
    endcase
  end

  assign idx_o     = idx_q;
  assign win_sel_o = dat_acc_i && win_hit;
  assign win_we_o  = win_sel_o && dat_wr_i;

  assert_ldsel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(ld_sel_q));
  assert_win_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_sel_o |-> (open_i && ld_sel_q == WIN_LD));
  assert_idx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(idx_q));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter bit          BASE_SEL = 1'b0,
  parameter logic [15:0] DEV_ID   = 16'h1010,
  parameter logic [7:0]  DEV_REV  = 8'h01,
  parameter logic [7:0]  WIN_LD   = 8'h06,
  parameter logic [7:0]  WIN_BASE = 8'h30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] io_addr_i,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        win_sel_o,
  output logic        win_we_o,
  output logic [7:0]  win_addr_o,
  output logic [7:0]  win_wdata_o,
  input  logic [7:0]  win_rdata_i
);
  localparam logic [15:0] IDX_ADDR = BASE_SEL ? 16'h004E : 16'h002E;
  localparam logic [15:0] DAT_ADDR = IDX_ADDR + 16'd1;

  logic       hit_idx, hit_dat, open, idx_load, dat_acc, dat_wr;
  logic [7:0] idx, dat_rdata;

  assign hit_idx = (io_addr_i == IDX_ADDR);
  assign hit_dat = (io_addr_i == DAT_ADDR);
  assign dat_acc = open && hit_dat && (io_rd_i || io_wr_i);
  assign dat_wr  = open && hit_dat && io_wr_i;

  cfg_lock_fsm u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (io_wr_i && hit_idx),
    .key_i      (io_wdata_i),
    .open_o     (open),
    .idx_load_o (idx_load)
  );

  cfg_reg_file #(
    .DEV_ID (DEV_ID), .DEV_REV (DEV_REV), .WIN_LD (WIN_LD), .WIN_BASE (WIN_BASE)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (open),
    .idx_load_i  (idx_load),
    .wdata_i     (io_wdata_i),
    .dat_acc_i   (dat_acc),
    .dat_wr_i    (dat_wr),
    .win_rdata_i (win_rdata_i),
    .idx_o       (idx),
    .dat_rdata_o (dat_rdata),
    .win_sel_o   (win_sel_o),
    .win_we_o    (win_we_o)
  );

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i && open) begin
      if (hit_idx)      io_rdata_o = idx;
      else if (hit_dat) io_rdata_o = dat_rdata;
    end
  end

  assign win_addr_o  = idx;
  assign win_wdata_o = io_wdata_i;

  assert_locked_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && io_rd_i) |-> io_rdata_o == 8'hFF);
  assert_foreign_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_idx && !hit_dat) |-> (io_rdata_o == 8'hFF && !win_sel_o));
  assert_win_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_i || io_wr_i) |-> !win_sel_o && !win_we_o);
endmodule

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata, win_addr, win_wdata, win_rdata;
  logic        win_sel, win_we;

  int checks = 0, errors = 0;
  // reference model state
  int lk = 0;
  int m_idx = 0, m_ld = 0;
  localparam int DEVID = 'h1010, DEVREV = 'h01;

  always #5 clk = ~clk;

  assign win_rdata = win_addr ^ 8'hA5;

  cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .win_sel_o(win_sel), .win_we_o(win_we),
    .win_addr_o(win_addr), .win_wdata_o(win_wdata), .win_rdata_i(win_rdata)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_data();
    case (m_idx)
      'h07: return m_ld;
      'h20: return DEVID >> 8;
      'h21: return DEVID & 'hFF;
      'h22: return DEVREV;
      'h23: return 'h19;
      'h24: return 'h34;
      default: return (m_ld == 6 && m_idx >= 'h30) ? (m_idx ^ 'hA5) : 0;
    endcase
  endfunction

  task automatic op(string req, int a, bit w, bit r, int d);
    int e_rd, e_sel;
    @(negedge clk);
    addr = a[15:0]; wr = w; rd = r; wdata = d[7:0];
    #1;
    e_rd = 'hFF;
    if (r && lk == 2) begin
      if (a == 'h2E) e_rd = m_idx;
      else if (a == 'h2F) e_rd = exp_data();
    end
    e_sel = (lk == 2 && a == 'h2F && (r || w) && m_ld == 6 && m_idx >= 'h30) ? 1 : 0;
    chk(req, "rdata", int'(rdata), e_rd);
    chk(req, "win_sel", int'(win_sel), e_sel);
    chk(req, "win_we", int'(win_we), (e_sel != 0 && w) ? 1 : 0);
    if (e_sel != 0) begin
      chk(req, "win_addr", int'(win_addr), m_idx);
      if (w) chk(req, "win_wdata", int'(win_wdata), d);
    end
    @(posedge clk);
    if (w && a == 'h2E) begin
      case (lk)
        0: lk = (d == 'h87) ? 1 : 0;
        1: lk = (d == 'h87) ? 2 : 0;
        default: if (d == 'hAA) lk = 0; else m_idx = d;
      endcase
    end else if (w && a == 'h2F && lk == 2 && m_idx == 'h07) m_ld = d;
    #1 wr = 0; rd = 0;
  endtask

  task automatic iw(string req, int d); op(req, 'h2E, 1, 0, d); endtask
  task automatic dw(string req, int d); op(req, 'h2F, 1, 0, d); endtask
  task automatic ir(string req);        op(req, 'h2E, 0, 1, 0); endtask
  task automatic dr(string req);        op(req, 'h2F, 0, 1, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 / R2: locked after reset
    dr("R1"); ir("R2");
    dw("R2", 'h55); iw("R2", 'h07); dw("R2", 'h33); dr("R2");
    // R3: broken sequence stays locked
    iw("R3", 'h87); iw("R3", 'h11); iw("R3", 'h87); dr("R3"); ir("R3");
    iw("R3", 'h00); iw("R3", 'h87); iw("R3", 'h87);
    ir("R1");
    iw("R5", 'h07); ir("R5"); dr("R1");
    dw("R6", 'h06); dr("R6");
    // R7: ids, write discarded
    for (int i = 'h20; i <= 'h24; i++) begin iw("R7", i); dr("R7"); dw("R7", 'h00); dr("R7"); end
    // R8: window
    iw("R8", 'h30); dr("R8"); dw("R8", 'h3C); iw("R8", 'hFF); dr("R8"); dw("R8", 'h01);
    iw("R10", 'h2F); dr("R10"); dw("R10", 'h77);
    iw("R10", 'h10); dr("R10");
    iw("R6", 'h07); dw("R6", 'h05); dr("R6");
    iw("R10", 'h30); dr("R10"); dw("R10", 'h12);
    // R9: other base ignored
    op("R9", 'h4E, 1, 0, 'hAA); op("R9", 'h4F, 0, 1, 0); op("R9", 'h4E, 0, 1, 0);
    op("R9", 'h2D, 1, 0, 'h07); ir("R9"); dr("R10");
    // R4: relock keeps state
    iw("R4", 'hAA); dr("R4"); ir("R4"); dw("R4", 'h06);
    iw("R4", 'h87); iw("R4", 'h87); ir("R4"); dr("R4");
    iw("R6", 'h07); dr("R6");
    // triple key latches 0x87
    iw("R4", 'hAA); iw("R3", 'h87); iw("R3", 'h87); iw("R5", 'h87); ir("R5");
    repeat (2) op("R8", 'h0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule